// File: doc/BRIEF.md
# Watchdog Timer with Timed-Sequence Protection

This block watches for a software hang. A counter runs on a dedicated slow watchdog clock. If software does not pulse the service strobe before the selected timeout, the block raises a reset request for a fixed number of watchdog cycles. After that the counter starts again from zero. Software controls the block through a five-bit control word on the system clock. The word holds a three-bit timeout select, an enable bit and a change-unlock bit.

Two mechanisms guard against a runaway program turning the watchdog off or stretching its timeout. The first is a short unlock window. A write that sets both the unlock bit and the enable bit opens the window. The unlock bit then reads 1 for four system cycles and clears by itself. Protected changes are accepted only from a write made inside that window with the unlock bit cleared. The second is a safety level held fixed on the `safety_lvl` input. It decides which fields need the window: at level 0 only disabling does, at level 1 disabling and timeout changes do, and at level 2 the watchdog is forced on and only timeout changes are possible, through the window.

The control-side state machine has two states. WIN_CLOSED moves to WIN_OPEN on an opening write. WIN_OPEN moves back to WIN_CLOSED on a committing write or when the window count runs out, and an opening write while open restarts the count. The counter-side machine has three states. CNT_OFF moves to CNT_RUN when the block is enabled. CNT_RUN moves to CNT_FIRE when the count reaches the selected limit, and back to CNT_OFF when the block is disabled. CNT_FIRE returns to CNT_RUN, or to CNT_OFF if the block is disabled, after the pulse length. The enable bit, the timeout select and a service toggle each cross into the watchdog domain through two-flop synchronizers.

Top module: `wdt_guard`

## Requirements
- R1: Control word layout: bits [2:0] hold the timeout select, bit 3 the enable and bit 4 the change-unlock. After reset the word reads enable = 1 at safety level 2 or 3 (3 acts as 2) and enable = 0 at levels 0 and 1. The select is 0 and the unlock bit is 0 at every level.
- R2: While enabled and not serviced, `wd_rst_out` rises every 2^(BASE_LOG2+sel) + PULSE_CYC watchdog cycles, for each of the eight select values.
- R3: Each reset request stays high for exactly PULSE_CYC watchdog cycles.
- R4: Service strobes that come faster than the selected period prevent any request. When the strobes stop, a request follows within one period.
- R5: A write with bits 4 and 3 both 1 opens the window. Bit 4 then reads 1 for exactly WIN_CYC (4) system cycles and reads 0 after that.
- R6: A write with bit 4 = 0 made while the window is open applies the protected fields and closes the window. The last accepted write falls on the 4th cycle after the opening write. A later write gets no protected access.
- R7: Level 0: writes set the select and set enable to 1 without restriction. Clearing enable only takes effect through the window.
- R8: Level 1: writes set enable to 1 without restriction. Select changes and clearing enable take effect only through the window.
- R9: Level 2: enable always reads 1 and cannot be cleared, even through the window. Select changes take effect only through the window.
- R10: While disabled, no reset request is raised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_sys | input | 1 | System clock for the register port and service strobe |
| rst_sys_n | input | 1 | Active-low reset, system domain |
| safety_lvl | input | 2 | Fixed protection level from non-volatile configuration |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 5 | Control word to write |
| rd_data | output | 5 | Current control word |
| kick | input | 1 | Service strobe, one system cycle wide |
| clk_wd | input | 1 | Dedicated watchdog clock |
| rst_wd_n | input | 1 | Active-low reset, watchdog domain |
| wd_rst_out | output | 1 | Reset request pulse, watchdog domain |

## Verification
A control-word write takes effect at the system edge that samples it. Its result can be read at the next falling edge, so register checks sample half a cycle after each write. The unlock bit is sampled at each of the four falling edges after the opening write, and again at the fifth. The synchronizers add two to three watchdog cycles of unknown phase before a new setting reaches the counter, so timing checks never measure from the write. They wait for two request edges to let the new setting settle. They then count watchdog falling edges from one rising request edge to the next, and count the high cycles of the pulse, and compare those counts with the period and width computed from the select value.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int PSEL_W  = 3;
    localparam int CFG_W   = PSEL_W + 2;
    localparam int BIT_EN  = PSEL_W;
    localparam int BIT_CHG = PSEL_W + 1;

    typedef enum logic {
        WIN_CLOSED,
        WIN_OPEN
    } win_state_t;

    typedef enum logic [1:0] {
        CNT_OFF,
        CNT_RUN,
        CNT_FIRE
    } cnt_state_t;
endpackage

// File: rtl/wdt_sync.sv
module wdt_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
#(
    parameter int WIN_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        lvl,
    input  logic              wr_en,
    input  logic              wr_chg,
    input  logic              wr_enb,
    input  logic [PSEL_W-1:0] wr_psel,
    output logic              en_q,
    output logic [PSEL_W-1:0] psel_q,
    output logic              win_open
);
    localparam int CW = $clog2(WIN_CYC + 1);

    win_state_t        st, st_nxt;
    logic [CW-1:0]     wcnt, wcnt_nxt;
    logic              en_r, en_nxt;
    logic [PSEL_W-1:0] psel_r, psel_nxt;
    logic              open_req, unlock;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= WIN_CLOSED;
            wcnt   <= '0;
            en_r   <= lvl[1];
            psel_r <= '0;
        end else begin
            st     <= st_nxt;
            wcnt   <= wcnt_nxt;
            en_r   <= en_nxt;
            psel_r <= psel_nxt;
        end
    end

    always_comb begin
        open_req = wr_en && wr_chg && wr_enb;
        unlock   = wr_en && (st == WIN_OPEN) && !wr_chg;
        st_nxt   = st;
        wcnt_nxt = wcnt;
        unique case (st)
            WIN_CLOSED: begin
                if (open_req) begin
                    st_nxt   = WIN_OPEN;
                    wcnt_nxt = CW'(WIN_CYC);
                end
            end
            WIN_OPEN: begin
                if (open_req) begin
                    wcnt_nxt = CW'(WIN_CYC);
                end else if (unlock || wcnt == CW'(1)) begin
                    st_nxt   = WIN_CLOSED;
                    wcnt_nxt = '0;
                end else begin
                    wcnt_nxt = wcnt - CW'(1);
                end
            end
            default: begin
                st_nxt   = WIN_CLOSED;
                wcnt_nxt = '0;
            end
        endcase

        en_nxt = en_r;
        if (lvl[1])               en_nxt = 1'b1;
        else if (wr_en && wr_enb) en_nxt = 1'b1;
        else if (unlock)          en_nxt = 1'b0;

        psel_nxt = psel_r;
        if (wr_en && (lvl == 2'd0 || unlock)) psel_nxt = wr_psel;
    end

    always_comb begin
        win_open = (st == WIN_OPEN);
        en_q     = en_r | lvl[1];
        psel_q   = psel_r;
    end
endmodule

// File: rtl/wdt_count.sv
module wdt_count
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 14,
    parameter int PULSE_CYC = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [PSEL_W-1:0] psel,
    input  logic              kick,
    output logic              req
);
    localparam int NSEL  = 1 << PSEL_W;
    localparam int CNT_W = BASE_LOG2 + NSEL;
    localparam int PW    = $clog2(PULSE_CYC + 1);

    cnt_state_t       st, st_nxt;
    logic [CNT_W-1:0] cnt, cnt_nxt, last;
    logic [PW-1:0]    pcnt, pcnt_nxt;

    always_comb last = (CNT_W'(1) << (BASE_LOG2 + int'(psel))) - CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= CNT_OFF;
            cnt  <= '0;
            pcnt <= '0;
        end else begin
            st   <= st_nxt;
            cnt  <= cnt_nxt;
            pcnt <= pcnt_nxt;
        end
    end

    always_comb begin
        st_nxt   = st;
        cnt_nxt  = cnt;
        pcnt_nxt = pcnt;
        unique case (st)
            CNT_OFF: begin
                cnt_nxt = '0;
                if (en) st_nxt = CNT_RUN;
            end
            CNT_RUN: begin
                if (!en) begin
                    st_nxt  = CNT_OFF;
                    cnt_nxt = '0;
                end else if (kick) begin
                    cnt_nxt = '0;
                end else if (cnt >= last) begin
                    st_nxt   = CNT_FIRE;
                    cnt_nxt  = '0;
                    pcnt_nxt = '0;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            CNT_FIRE: begin
                cnt_nxt = '0;
                if (pcnt == PW'(PULSE_CYC - 1)) begin
                    st_nxt   = en ? CNT_RUN : CNT_OFF;
                    pcnt_nxt = '0;
                end else begin
                    pcnt_nxt = pcnt + PW'(1);
                end
            end
            default: st_nxt = CNT_OFF;
        endcase
    end

    always_comb req = (st == CNT_FIRE);
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int BASE_LOG2 = 14,
    parameter int PULSE_CYC = 16,
    parameter int WIN_CYC   = 4
) (
    input  logic             clk_sys,
    input  logic             rst_sys_n,
    input  logic [1:0]       safety_lvl,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] rd_data,
    input  logic             kick,
    input  logic             clk_wd,
    input  logic             rst_wd_n,
    output logic             wd_rst_out
);
    logic              en_q, win_open, kick_tgl, kick_last, kick_w;
    logic [PSEL_W-1:0] psel_q;
    logic [PSEL_W+1:0] xin, xout;

    wdt_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
        .clk      (clk_sys),
        .rst_n    (rst_sys_n),
        .lvl      (safety_lvl),
        .wr_en    (wr_en),
        .wr_chg   (wr_data[BIT_CHG]),
        .wr_enb   (wr_data[BIT_EN]),
        .wr_psel  (wr_data[PSEL_W-1:0]),
        .en_q     (en_q),
        .psel_q   (psel_q),
        .win_open (win_open)
    );

    assign rd_data = {win_open, en_q, psel_q};

    always_ff @(posedge clk_sys or negedge rst_sys_n) begin
        if (!rst_sys_n) kick_tgl <= 1'b0;
        else if (kick)  kick_tgl <= ~kick_tgl;
    end

    assign xin = {kick_tgl, en_q, psel_q};

    wdt_sync #(.W(PSEL_W + 2), .STAGES(2)) u_sync (
        .clk   (clk_wd),
        .rst_n (rst_wd_n),
        .d     (xin),
        .q     (xout)
    );

    always_ff @(posedge clk_wd or negedge rst_wd_n) begin
        if (!rst_wd_n) kick_last <= 1'b0;
        else           kick_last <= xout[PSEL_W+1];
    end

    assign kick_w = xout[PSEL_W+1] ^ kick_last;

    wdt_count #(.BASE_LOG2(BASE_LOG2), .PULSE_CYC(PULSE_CYC)) u_cnt (
        .clk   (clk_wd),
        .rst_n (rst_wd_n),
        .en    (xout[PSEL_W]),
        .psel  (xout[PSEL_W-1:0]),
        .kick  (kick_w),
        .req   (wd_rst_out)
    );
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
    import wdt_pkg::*;
#(
    parameter int WIN_CYC   = 4,
    parameter int PULSE_CYC = 16
) (
    input logic             clk_sys,
    input logic             rst_sys_n,
    input logic [1:0]       safety_lvl,
    input logic             wr_en,
    input logic             wr_chg,
    input logic             wr_enb,
    input logic [CFG_W-1:0] rd_data,
    input logic             clk_wd,
    input logic             rst_wd_n,
    input logic             wd_rst_out
);
    localparam int WR_W = $clog2(WIN_CYC + 2) + 1;
    localparam int HW   = $clog2(PULSE_CYC + 1) + 1;

    logic [WR_W-1:0] win_run;
    logic [HW-1:0]   hi_run;

    always_ff @(posedge clk_sys or negedge rst_sys_n) begin
        if (!rst_sys_n)                    win_run <= '0;
        else if (wr_en && wr_chg && wr_enb) win_run <= WR_W'(1);
        else if (rd_data[BIT_CHG])         win_run <= win_run + WR_W'(1);
        else                               win_run <= '0;
    end

    always_ff @(posedge clk_wd or negedge rst_wd_n) begin
        if (!rst_wd_n)       hi_run <= '0;
        else if (wd_rst_out) hi_run <= hi_run + HW'(1);
        else                 hi_run <= '0;
    end

    // R5
    window_len_chk: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        rd_data[BIT_CHG] |-> (win_run != '0 && win_run <= WR_W'(WIN_CYC)));

    // R9
    strict_enable_chk: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        safety_lvl[1] |-> rd_data[BIT_EN]);

    // R7
    disable_guard_chk: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        $fell(rd_data[BIT_EN]) |-> ($past(rd_data[BIT_CHG]) && !safety_lvl[1]));

    // R8
    psel_guard_chk: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        (safety_lvl != 2'd0 && !rd_data[BIT_CHG]) |=> $stable(rd_data[PSEL_W-1:0]));

    // R1
    cfg_hold_chk: assert property (@(posedge clk_sys) disable iff (!rst_sys_n)
        !wr_en |=> $stable(rd_data[BIT_EN:0]));

    // R3
    pulse_len_chk: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
        wd_rst_out |-> hi_run < HW'(PULSE_CYC));

    // R3
    pulse_full_chk: assert property (@(posedge clk_wd) disable iff (!rst_wd_n)
        $fell(wd_rst_out) |-> $past(hi_run) == HW'(PULSE_CYC - 1));
endmodule

bind wdt_guard wdt_guard_chk #(.WIN_CYC(WIN_CYC), .PULSE_CYC(PULSE_CYC)) u_guard_chk (
    .clk_sys    (clk_sys),
    .rst_sys_n  (rst_sys_n),
    .safety_lvl (safety_lvl),
    .wr_en      (wr_en),
    .wr_chg     (wr_data[4]),
    .wr_enb     (wr_data[3]),
    .rd_data    (rd_data),
    .clk_wd     (clk_wd),
    .rst_wd_n   (rst_wd_n),
    .wd_rst_out (wd_rst_out)
);

// File: tb/test_wdt_guard.sv
module test_wdt_guard;
    localparam int BASE = 2;
    localparam int PUL  = 3;
    localparam int WIN  = 4;

    logic       clk_sys = 0, clk_wd = 0;
    logic       rst_sys_n = 0, rst_wd_n = 0;
    logic [1:0] lvl = 0;
    logic       wr_en = 0, kick = 0;
    logic [4:0] wr_data = 0;
    logic [4:0] rd_data;
    logic       wd_rst_out;

    int vectors = 0, miscomp = 0, fires = 0;
    logic prev_out = 0;

    always #4  clk_sys = ~clk_sys;
    always #20 clk_wd  = ~clk_wd;

    wdt_guard #(.BASE_LOG2(BASE), .PULSE_CYC(PUL), .WIN_CYC(WIN)) i_wdt_guard (
        .clk_sys    (clk_sys),
        .rst_sys_n  (rst_sys_n),
        .safety_lvl (lvl),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .kick       (kick),
        .clk_wd     (clk_wd),
        .rst_wd_n   (rst_wd_n),
        .wd_rst_out (wd_rst_out)
    );

    always @(negedge clk_wd) begin
        if (wd_rst_out && !prev_out) fires++;
        prev_out <= wd_rst_out;
    end

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscomp++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] l);
        lvl = l;
        rst_sys_n = 0;
        rst_wd_n  = 0;
        repeat (3) @(negedge clk_wd);
        @(negedge clk_sys) rst_sys_n = 1;
        @(negedge clk_wd)  rst_wd_n  = 1;
        @(negedge clk_sys);
    endtask

    task automatic wr(input logic [4:0] d);
        @(negedge clk_sys);
        wr_en = 1; wr_data = d;
        @(negedge clk_sys);
        wr_en = 0; wr_data = 0;
    endtask

    task automatic pulse_kick();
        @(negedge clk_sys) kick = 1;
        @(negedge clk_sys) kick = 0;
    endtask

    task automatic wait_rise(input int maxn, output int n);
        logic l;
        l = wd_rst_out;
        n = 0;
        while (n <= maxn) begin
            @(negedge clk_wd);
            n++;
            if (wd_rst_out && !l) return;
            l = wd_rst_out;
        end
        n = -1;
    endtask

    task automatic measure(output int per, output int wid);
        logic l;
        bit low_seen;
        per = 0; wid = 1; l = 1; low_seen = 0;
        while (per < 5000) begin
            @(negedge clk_wd);
            per++;
            if (wd_rst_out && !l) return;
            if (wd_rst_out && !low_seen) wid++;
            if (!wd_rst_out) low_seen = 1;
            l = wd_rst_out;
        end
        per = -1;
    endtask

    initial begin
        #(8 * 150000);
        miscomp++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end

    initial begin
        int n, per, wid, f0;

        // Level 0
        do_reset(2'd0);
        chk("R1 level0 reset word", int'(rd_data), 0);
        f0 = fires;
        repeat (100) @(negedge clk_wd);
        chk("R10 no request while disabled after reset", fires - f0, 0);

        for (int ps = 0; ps < 8; ps++) begin
            wr(5'b01000 | 5'(ps));
            chk("R7 level0 free select and enable", int'(rd_data), 8 | ps);
            wait_rise(2000, n);
            wait_rise(2000, n);
            measure(per, wid);
            chk("R2 request period", per, (1 << (BASE + ps)) + PUL);
            chk("R3 request width", wid, PUL);
        end

        wr(5'b01010);
        repeat (10) @(negedge clk_wd);
        repeat (5) begin pulse_kick(); repeat (30) @(negedge clk_sys); end
        f0 = fires;
        repeat (50) begin pulse_kick(); repeat (30) @(negedge clk_sys); end
        chk("R4 serviced watchdog stays quiet", fires - f0, 0);
        wait_rise(40, n);
        chk("R4 request after service stops", int'(n > 0), 1);

        wr(5'b00010);
        chk("R7 plain disable ignored", int'(rd_data), 5'b01010);

        wr(5'b11010);
        for (int k = 0; k < WIN; k++) begin
            chk("R5 unlock bit high in window", int'(rd_data[4]), 1);
            @(negedge clk_sys);
        end
        chk("R5 unlock bit self-clears", int'(rd_data[4]), 0);
        wr(5'b00010);
        chk("R6 write after window ignored", int'(rd_data), 5'b01010);

        wr(5'b11010);
        repeat (2) @(negedge clk_sys);
        wr(5'b00010);
        chk("R6 R7 last-slot disable accepted", int'(rd_data), 5'b00010);
        repeat (10) @(negedge clk_wd);
        f0 = fires;
        repeat (200) @(negedge clk_wd);
        chk("R10 no request after disable", fires - f0, 0);

        wr(5'b11010);
        wr(5'b00011);
        chk("R6 commit applies and closes window", int'(rd_data), 5'b00011);

        // Level 1
        do_reset(2'd1);
        chk("R1 level1 reset word", int'(rd_data), 0);
        wr(5'b01101);
        chk("R8 enable free, select protected", int'(rd_data), 5'b01000);
        wr(5'b00000);
        chk("R8 plain disable ignored", int'(rd_data), 5'b01000);
        wr(5'b11000);
        wr(5'b00110);
        chk("R8 timed sequence disables and selects", int'(rd_data), 5'b00110);
        wr(5'b01000);
        chk("R8 re-enable keeps select", int'(rd_data), 5'b01110);
        wr(5'b11110);
        repeat (WIN) @(negedge clk_sys);
        wr(5'b01001);
        chk("R6 level1 late select ignored", int'(rd_data), 5'b01110);

        // Level 2
        do_reset(2'd2);
        chk("R1 R9 level2 reset word", int'(rd_data), 5'b01000);
        wait_rise(40, n);
        chk("R9 runs from reset", int'(n > 0), 1);
        measure(per, wid);
        chk("R9 R2 level2 period", per, (1 << BASE) + PUL);
        wr(5'b00011);
        chk("R9 plain select and disable ignored", int'(rd_data), 5'b01000);
        wr(5'b11000);
        wr(5'b00011);
        chk("R9 sequence changes select only", int'(rd_data), 5'b01011);
        wait_rise(2000, n);
        wait_rise(2000, n);
        measure(per, wid);
        chk("R9 R2 period after select change", per, (1 << (BASE + 3)) + PUL);

        // Level 3 behaves as 2
        do_reset(2'd3);
        chk("R1 level3 reset word", int'(rd_data), 5'b01000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
        $finish;
    end
endmodule